// File: doc/BRIEF.md
# Conditional Branch and Condition-Code Update Unit

This unit takes one 16-bit instruction word together with the already-incremented program counter and the four condition flags. It decides two things. For a one-word conditional branch, it evaluates the branch condition against the flags and computes the redirect address. For a condition-code instruction, it sets or clears any subset of the flags. Any other instruction word passes through with no effect: the branch is not taken and the flags do not change.

Results are registered. A word presented with `in_valid` high produces its outcome one clock later, marked by `out_valid`. The fetch stage uses `take` and `target` to redirect the program counter, and writes `cc_out` back to the flag register. The flag vector is ordered N, Z, V, C from bit 3 down to bit 0.

Top module: `bcf_unit`

## Requirements
- R1: Synchronous active-high reset clears `out_valid`, `take`, `target` and `cc_out` to zero. A word accepted with `in_valid` high sets `out_valid` on the next rising edge, and `out_valid` is low in every cycle that follows a cycle without `in_valid`.
- R2: A word is a branch when bits 14:11 are zero and either bit 15 is set or bits 10:8 are non-zero. Bits 10:9 select a condition, bit 8 is the sense, and the branch is taken when the selected condition equals the sense bit.
- R3: With bit 15 clear, the conditions are: code 0 is always true (sense 1 only, the unconditional branch), code 1 is Z, code 2 is N XOR V, and code 3 is Z OR (N XOR V).
- R4: With bit 15 set, the conditions are: code 0 is N, code 1 is C OR Z (the higher branch is taken only when C and Z are both clear), code 2 is V, and code 3 is C.
- R5: For every branch word, whether taken or not, `target` equals the incremented PC plus the sign-extended bits 7:0 times two, modulo 2^16. Offsets +127 and -128 give +254 and -256.
- R6: A branch word leaves `cc_out` equal to the flags that were presented with it.
- R7: A word whose bits 15:5 are 00000000101 (binary) is a condition-code instruction. Bit 4 selects set (1) or clear (0), and bits 3:0 are a mask over N, Z, V, C, in the same bit order as the flag vector. Each flag whose mask bit is set becomes the value of bit 4, and the other flags keep their values.
- R8: A condition-code instruction with an all-zero mask leaves every flag unchanged, whether bit 4 is set or clear.
- R9: Any word that is neither a branch nor a condition-code instruction gives `take` = 0, `target` equal to the incremented PC, and unchanged flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word presented this cycle |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | Program counter already advanced past the instruction |
| cc_in | input | 4 | Current flags {N,Z,V,C} |
| out_valid | output | 1 | Registered results are valid |
| take | output | 1 | Branch taken |
| target | output | 16 | Branch destination (incremented PC for non-branches) |
| cc_out | output | 4 | Updated flags {N,Z,V,C} |

## Verification
Some properties are checked on every cycle by the assertions. These are the one-cycle valid timing after reset, flags being held across any branch word, an empty mask leaving the flags unchanged, the unconditional branch always being taken, and non-branch words never being taken. The bench's scenarios are needed for the rest: the full truth table of all fifteen branch encodings against all sixteen flag combinations, the exact target arithmetic at the offset extremes and on address wrap, and the per-flag effect of arbitrary set and clear masks.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

    localparam int IW   = 16;
    localparam int OFFW = 8;
    localparam int CCW  = 4;

    // Flag vector: bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccode_t;

    typedef enum logic [1:0] {
        K_OTHER  = 2'd0,
        K_BRANCH = 2'd1,
        K_CCOP   = 2'd2
    } kind_t;

    typedef struct packed {
        kind_t            kind;
        logic             hi_grp;
        logic [1:0]       code;
        logic             sense;
        logic [OFFW-1:0]  off;
        logic             set_sel;
        ccode_t           mask;
    } dec_t;

    // Upper eleven bits that mark a condition-code instruction
    localparam logic [10:0] CCOP_TAG = 11'b000_0000_0101;

    function automatic dec_t decode_word(input logic [IW-1:0] w);
        dec_t d;
        d.hi_grp  = w[15];
        d.code    = w[10:9];
        d.sense   = w[8];
        d.off     = w[7:0];
        d.set_sel = w[4];
        d.mask    = ccode_t'(w[3:0]);
        if (w[14:11] == 4'b0000 && (w[15] || w[10:8] != 3'b000))
            d.kind = K_BRANCH;
        else if (w[15:5] == CCOP_TAG)
            d.kind = K_CCOP;
        else
            d.kind = K_OTHER;
        return d;
    endfunction

    function automatic ccode_t apply_mask(input ccode_t cur, input ccode_t m,
                                          input logic setv);
        ccode_t r;
        if (setv) r = cur | m;
        else      r = cur & ~m;
        return r;
    endfunction

endpackage

// File: rtl/bcf_decode.sv
module bcf_decode
    import bcf_pkg::*;
(
    input  logic [IW-1:0] word,
    output dec_t          dec
);
    always_comb dec = decode_word(word);
endmodule

// File: rtl/bcf_cond.sv
module bcf_cond
    import bcf_pkg::*;
(
    input  logic       hi_grp,
    input  logic [1:0] code,
    input  logic       sense,
    input  ccode_t     cc,
    output logic       taken
);
    logic sgn_lt;
    logic base;

    always_comb begin
        sgn_lt = cc.n ^ cc.v;
        if (!hi_grp) begin
            unique case (code)
                2'd0: base = 1'b1;
                2'd1: base = cc.z;
                2'd2: base = sgn_lt;
                default: base = cc.z | sgn_lt;
            endcase
        end else begin
            unique case (code)
                2'd0: base = cc.n;
                2'd1: base = cc.c | cc.z;
                2'd2: base = cc.v;
                default: base = cc.c;
            endcase
        end
        taken = (base == sense);
    end
endmodule

// File: rtl/bcf_target.sv
module bcf_target
    import bcf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]   pc_next,
    input  logic [OFFW-1:0] off,
    output logic [AW-1:0]   dest
);
    localparam int EXTW = AW - OFFW - 1;
    logic [AW-1:0] byte_off;

    generate
        if (EXTW > 0) begin : g_ext
            assign byte_off = {{EXTW{off[OFFW-1]}}, off, 1'b0};
        end else begin : g_trunc
            assign byte_off = AW'({off, 1'b0});
        end
    endgenerate

    assign dest = pc_next + byte_off;
endmodule

// File: rtl/bcf_unit.sv
module bcf_unit
    import bcf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [IW-1:0]       instr,
    input  logic [AW-1:0]       pc_next,
    input  logic [CCW-1:0]      cc_in,
    output logic                out_valid,
    output logic                take,
    output logic [AW-1:0]       target,
    output logic [CCW-1:0]      cc_out
);
    dec_t          dec;
    logic          cond_hit;
    logic [AW-1:0] br_dest;
    ccode_t        cc_cur;
    ccode_t        cc_nxt;
    logic          take_nxt;
    logic [AW-1:0] tgt_nxt;

    assign cc_cur = ccode_t'(cc_in);

    bcf_decode u_dec (
        .word (instr),
        .dec  (dec)
    );

    bcf_cond u_cond (
        .hi_grp (dec.hi_grp),
        .code   (dec.code),
        .sense  (dec.sense),
        .cc     (cc_cur),
        .taken  (cond_hit)
    );

    bcf_target #(.AW(AW)) u_tgt (
        .pc_next (pc_next),
        .off     (dec.off),
        .dest    (br_dest)
    );

    always_comb begin
        take_nxt = 1'b0;
        tgt_nxt  = pc_next;
        cc_nxt   = cc_cur;
        unique case (dec.kind)
            K_BRANCH: begin
                take_nxt = cond_hit;
                tgt_nxt  = br_dest;
            end
            K_CCOP:  cc_nxt = apply_mask(cc_cur, dec.mask, dec.set_sel);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            take      <= 1'b0;
            target    <= '0;
            cc_out    <= '0;
        end else begin
            out_valid <= in_valid;
            take      <= in_valid & take_nxt;
            if (in_valid) begin
                target <= tgt_nxt;
                cc_out <= cc_nxt;
            end
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !take));

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drops_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !take));

    p_always_branch_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:8] == 8'h01) |=> take);

    p_flags_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.kind == K_BRANCH) |=> (cc_out == $past(cc_in)));

    p_empty_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.kind == K_CCOP && dec.mask == 4'b0000)
        |=> (cc_out == $past(cc_in)));

    p_no_take_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.kind != K_BRANCH) |=> !take);

    p_target_parity_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (target[0] == $past(pc_next[0])));

endmodule

// File: tb/bcf_unit_tb_top.sv
module bcf_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_next = '0;
    logic [3:0]  cc_in = '0;
    logic        out_valid;
    logic        take;
    logic [15:0] target;
    logic [3:0]  cc_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] w;
        logic        tk;
        logic [15:0] tg;
        logic [3:0]  cc;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    bcf_unit #(.AW(16)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .instr     (instr),
        .pc_next   (pc_next),
        .cc_in     (cc_in),
        .out_valid (out_valid),
        .take      (take),
        .target    (target),
        .cc_out    (cc_out)
    );

    // Reference model written from the requirements
    function automatic logic ref_taken(input logic [15:0] w, input logic [3:0] f);
        logic n, z, v, c;
        n = f[3]; z = f[2]; v = f[1]; c = f[0];
        case ({w[15], w[10:9], w[8]})
            4'b0001: return 1'b1;
            4'b0010: return !z;
            4'b0011: return z;
            4'b0100: return n == v;
            4'b0101: return n != v;
            4'b0110: return !(z || (n != v));
            4'b0111: return z || (n != v);
            4'b1000: return !n;
            4'b1001: return n;
            4'b1010: return !c && !z;
            4'b1011: return c || z;
            4'b1100: return !v;
            4'b1101: return v;
            4'b1110: return !c;
            4'b1111: return c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_br(input logic [15:0] w);
        return (w[14:11] == 4'd0) && (w[15] || w[10:8] != 3'd0);
    endfunction

    task automatic send(input logic [15:0] w, input logic [15:0] pc,
                        input logic [3:0] f, input string req);
        exp_t e;
        int   offs;
        e.w = w; e.req = req; e.tk = 1'b0; e.tg = pc; e.cc = f;
        if (is_br(w)) begin
            offs = $signed(w[7:0]);
            e.tk = ref_taken(w, f);
            e.tg = 16'(int'(pc) + offs * 2);
        end else if (w[15:5] == 11'b00000000101) begin
            for (int i = 0; i < 4; i++)
                if (w[i]) e.cc[i] = w[4];
        end
        sb.push_back(e);
        in_valid = 1'b1; instr = w; pc_next = pc; cc_in = f;
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R1: unexpected out_valid, actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (take !== e.tk || target !== e.tg || cc_out !== e.cc) begin
                    bad++;
                    $display("FAIL %s: word=%o actual take=%b tgt=%h cc=%b expected take=%b tgt=%h cc=%b",
                             e.req, e.w, take, target, cc_out, e.tk, e.tg, e.cc);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        total++;
        if (out_valid !== 1'b0 || take !== 1'b0 || target !== 16'h0 || cc_out !== 4'h0) begin
            bad++;
            $display("FAIL R1: reset actual v=%b t=%b tg=%h cc=%b expected all zero",
                     out_valid, take, target, cc_out);
        end
        rst = 1'b0;
        @(negedge clk);

        // R3 unconditional branch, R5 offsets and wrap
        send(16'o000405, 16'h1000, 4'b0000, "R3");
        send(16'o000577, 16'h1000, 4'b1111, "R5");
        send(16'o000600, 16'h1000, 4'b0101, "R5");
        send(16'o000412, 16'hFFF0, 4'b0000, "R5");
        send(16'o001776, 16'h0002, 4'b0000, "R5");
        // R5 not-taken branch still reports its target (BEQ with Z clear)
        send(16'o001403, 16'h2000, 4'b0000, "R5");

        // R2/R3/R4/R6 every branch encoding against every flag value
        for (int b = 0; b < 2; b++)
            for (int cs = 0; cs < 8; cs++)
                for (int f = 0; f < 16; f++) begin
                    logic [15:0] w;
                    if (b == 0 && cs == 0) continue;
                    w = {b[0], 4'b0000, cs[2:0], 8'((cs * 37 + f * 11) & 8'hFF)};
                    send(w, 16'(16'h4000 + f * 2), f[3:0], b ? "R4" : "R3");
                end

        // R7 set and clear masks
        send(16'o000261, 16'h0100, 4'b0000, "R7");
        send(16'o000257, 16'h0100, 4'b1111, "R7");
        send(16'o000277, 16'h0100, 4'b0000, "R7");
        send(16'o000250, 16'h0100, 4'b1111, "R7");
        send(16'o000266, 16'h0100, 4'b1001, "R7");
        send(16'o000245, 16'h0100, 4'b0111, "R7");

        // R8 empty mask both senses
        send(16'o000240, 16'h0200, 4'b1010, "R8");
        send(16'o000260, 16'h0200, 4'b0101, "R8");
        send(16'o000240, 16'h0200, 4'b1111, "R8");

        // R9 other words
        send(16'o000000, 16'h0300, 4'b1111, "R9");
        send(16'o000300, 16'h0302, 4'b0110, "R9");
        send(16'o010203, 16'h0304, 4'b1001, "R9");
        send(16'o000207, 16'h0306, 4'b0011, "R9");
        send(16'o004737, 16'h0308, 4'b1100, "R9");
        send(16'o104000, 16'h030A, 4'b1111, "R9");

        in_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R1 idle after drain
        total++;
        if (out_valid !== 1'b0 || take !== 1'b0) begin
            bad++;
            $display("FAIL R1: idle actual v=%b t=%b expected 0 0", out_valid, take);
        end
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R1: results missing actual=%0d expected=0", sb.size());
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule